// File: doc/BRIEF.md
# Banked Unaligned Multi-Word Fetch Memory

This block is an instruction store for a front end that consumes several instruction words per cycle. One read request with any word address returns LANES consecutive words one clock later, whether or not the address is a multiple of LANES. The words come back in program order: lane 0 holds the word at the start address, lane 1 the word after it, and so on.

The storage is divided into LANES single-port banks interleaved by word. Word w lives in bank `w % LANES` at row `w / LANES`. On a read, each bank works out its own row. A bank whose index is below the start offset is already past the start word in the current row, so it reads the following row instead. The bank outputs are then rotated by the start offset, and that offset is registered beside the bank reads so that it lines up with the data. A preload port writes one word per cycle. When a write and a read request arrive in the same cycle, the write takes the banks.

A small controller follows what the banks did in the previous cycle. In state S_IDLE no bank access took place. In S_LOAD a preload write took place. In S_DELIVER a read was accepted and its data is on the output. From any state, the next state is S_LOAD on a write, S_DELIVER on a read request without a write, and S_IDLE otherwise. Reset enters S_IDLE.

Top module: `fetch_mem`

## Requirements
- R1: While reset is asserted, and after it until the first accepted read, `rd_valid` is 0.
- R2: A read is accepted on a clock edge where `rd_req`=1 and `wr_en`=0. `rd_valid` is 1 in exactly the cycle that follows an accepted read, and 0 in every other cycle.
- R3: For a start address that is a multiple of LANES, lane i (bits `[i*WORD_W +: WORD_W]` of `rd_data`) holds the word at address start+i.
- R4: For a start address that is not a multiple of LANES, lane i also holds the word at start+i. Banks below the offset supply words from the next row.
- R5: Addresses wrap at LANES*ROWS, so lane i holds the word at (start+i) mod (LANES*ROWS).
- R6: A write with `wr_en`=1 stores `wr_data` as the word at `wr_addr`. Later reads return the new value and leave the other words unchanged.
- R7: A read request that arrives in the same cycle as a write is dropped: `rd_valid` is 0 in the next cycle, and the write still takes effect.
- R8: `rd_data` keeps its value through any cycle that follows a cycle with no accepted read, including write cycles.
- R9: Reads may be accepted on consecutive cycles. Each one returns its own words, one cycle after its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Start word address of the read |
| wr_en | input | 1 | Preload write enable |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | WORD_W | Word to write |
| rd_valid | output | 1 | Read data valid (one cycle after an accepted read) |
| rd_data | output | LANES*WORD_W | LANES words; lane i sits at bits i*WORD_W and holds the word at start+i |

## Verification
The assertions that check the data assume that LANES and ROWS are powers of two, and that every word has been written before any read can return it, so that no read brings back an unknown value. The stimulus meets this by preloading the whole store before its first read, with no read request in that phase. The check that the output holds its value assumes the reset phase issues no reads, and the bench drives only idle inputs during reset. The bench then issues reads at every offset, including reads that cross the top of the address space. It also overwrites words, and it makes reads and writes collide on purpose to exercise the drop rule.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    // Bank activity seen in the previous cycle
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LOAD    = 2'd1,
        S_DELIVER = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/fetch_bank.sv
module fetch_bank #(
    parameter int WORD_W = 32,
    parameter int ROWS   = 16,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    logic [WORD_W-1:0] store_q [ROWS];

    // One port: a write in a cycle leaves the read register untouched
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store_q[row] <= din;
            end else begin
                dout <= store_q[row];
            end
        end
    end

endmodule

// File: rtl/fetch_row_sel.sv
module fetch_row_sel #(
    parameter int LANES = 4,
    parameter int ROWS  = 16,
    parameter int BANK  = 0,
    localparam int OFF_W = $clog2(LANES),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0] base_row,
    input  logic [OFF_W-1:0] start_off,
    output logic [ROW_W-1:0] bank_row
);

    localparam logic [OFF_W-1:0] BANK_IDX = OFF_W'(BANK);

    // Banks below the start offset hold words that come before the start
    // word in this row, so they must read the next row (wrapping at the top)
    always_comb begin
        if (BANK_IDX < start_off) begin
            bank_row = base_row + ROW_W'(1);
        end else begin
            bank_row = base_row;
        end
    end

endmodule

// File: rtl/fetch_rotator.sv
module fetch_rotator #(
    parameter int LANES  = 4,
    parameter int WORD_W = 32,
    localparam int OFF_W = $clog2(LANES),
    localparam int BUS_W = LANES * WORD_W
) (
    input  logic [BUS_W-1:0] bank_bus,
    input  logic [OFF_W-1:0] amount,
    output logic [BUS_W-1:0] lane_bus
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] src;
        // Lane i takes bank (i + amount) mod LANES
        always_comb begin
            src = OFF_W'(i) + amount;
            lane_bus[i*WORD_W +: WORD_W] = bank_bus[src*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/fetch_mem.sv
module fetch_mem
    import fetch_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = 32,
    parameter int ROWS   = 16,
    localparam int OFF_W  = $clog2(LANES),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = OFF_W + ROW_W,
    localparam int BUS_W  = LANES * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [BUS_W-1:0]  rd_data
);

    fetch_state_e      st_q, st_d;
    logic              rd_accept;
    logic [OFF_W-1:0]  rd_off, wr_off, rot_q;
    logic [ROW_W-1:0]  rd_base, wr_base;
    logic [BUS_W-1:0]  bank_bus;

    assign rd_accept = rd_req & ~wr_en;
    assign rd_off    = rd_addr[OFF_W-1:0];
    assign rd_base   = rd_addr[ADDR_W-1:OFF_W];
    assign wr_off    = wr_addr[OFF_W-1:0];
    assign wr_base   = wr_addr[ADDR_W-1:OFF_W];

    // Next state: what the banks do this cycle
    always_comb begin
        st_d = S_IDLE;
        unique case (st_q)
            S_IDLE, S_LOAD, S_DELIVER: begin
                if (wr_en) begin
                    st_d = S_LOAD;
                end else if (rd_req) begin
                    st_d = S_DELIVER;
                end else begin
                    st_d = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Rotation amount travels with the read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rot_q <= '0;
        end else if (rd_accept) begin
            rot_q <= rd_off;
        end
    end

    // Outputs from state
    always_comb begin
        rd_valid = 1'b0;
        unique case (st_q)
            S_DELIVER:      rd_valid = 1'b1;
            S_IDLE, S_LOAD: rd_valid = 1'b0;
            default:        rd_valid = 1'b0;
        endcase
    end

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [ROW_W-1:0] rd_row;
        logic [ROW_W-1:0] acc_row;
        logic             bank_we;
        logic             bank_en;

        fetch_row_sel #(
            .LANES (LANES),
            .ROWS  (ROWS),
            .BANK  (b)
        ) u_row (
            .base_row  (rd_base),
            .start_off (rd_off),
            .bank_row  (rd_row)
        );

        assign bank_we = wr_en && (wr_off == OFF_W'(b));
        assign bank_en = rd_accept | bank_we;
        assign acc_row = wr_en ? wr_base : rd_row;

        fetch_bank #(
            .WORD_W (WORD_W),
            .ROWS   (ROWS)
        ) u_bank (
            .clk  (clk),
            .en   (bank_en),
            .we   (bank_we),
            .row  (acc_row),
            .din  (wr_data),
            .dout (bank_bus[b*WORD_W +: WORD_W])
        );
    end

    fetch_rotator #(
        .LANES  (LANES),
        .WORD_W (WORD_W)
    ) u_rot (
        .bank_bus (bank_bus),
        .amount   (rot_q),
        .lane_bus (rd_data)
    );

endmodule

// File: rtl/fetch_mem_chk.sv
module fetch_mem_chk #(
    parameter int BUS_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             wr_en,
    input logic             rd_valid,
    input logic [BUS_W-1:0] rd_data
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!rd_valid);
        end
    end

    // R2
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_en) |=> rd_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !wr_en) |=> !rd_valid);

    // R7
    collision_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_en) |=> !rd_valid);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !wr_en) |=> $stable(rd_data));

    // R4
    known_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$isunknown(rd_data));

endmodule

bind fetch_mem fetch_mem_chk #(
    .BUS_W (BUS_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_en    (wr_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/fetch_mem_tb_top.sv
module fetch_mem_tb_top;

    localparam int LANES  = 4;
    localparam int WORD_W = 32;
    localparam int ROWS   = 16;
    localparam int TOTAL  = LANES * ROWS;
    localparam int ADDR_W = $clog2(TOTAL);
    localparam int BUS_W  = LANES * WORD_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              rd_valid;
    logic [BUS_W-1:0]  rd_data;

    always #10 clk = ~clk;

    fetch_mem #(
        .LANES  (LANES),
        .WORD_W (WORD_W),
        .ROWS   (ROWS)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    typedef struct {
        logic             v;
        logic             cmp;
        logic [BUS_W-1:0] data;
        int               tag;
    } item_t;

    item_t            exp_q[$];
    logic [WORD_W-1:0] model [TOTAL];
    logic [BUS_W-1:0]  last_exp = '0;
    logic              have_prev = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pattern(int k);
        return (32'(k) * 32'h0101_0101) ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [BUS_W-1:0] expect_read(int a);
        logic [BUS_W-1:0] e;
        for (int i = 0; i < LANES; i++) begin
            e[i*WORD_W +: WORD_W] = model[(a + i) % TOTAL];
        end
        return e;
    endfunction

    task automatic push(logic v, logic cmp, logic [BUS_W-1:0] d, int t);
        item_t it;
        it.v = v; it.cmp = cmp; it.data = d; it.tag = t;
        exp_q.push_back(it);
    endtask

    task automatic do_write(int a, logic [WORD_W-1:0] d);
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        model[a] = d;
        push(1'b0, have_prev, last_exp, 8);
    endtask

    task automatic do_read(int a, int t);
        @(negedge clk);
        wr_en = 1'b0; rd_req = 1'b1; rd_addr = ADDR_W'(a);
        last_exp = expect_read(a);
        have_prev = 1'b1;
        push(1'b1, 1'b1, last_exp, t);
    endtask

    task automatic do_collide(int ra, int wa, logic [WORD_W-1:0] d);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = ADDR_W'(ra);
        wr_en = 1'b1; wr_addr = ADDR_W'(wa); wr_data = d;
        model[wa] = d;
        push(1'b0, have_prev, last_exp, 7);
    endtask

    task automatic do_idle(int t);
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b0;
        push(1'b0, have_prev, last_exp, t);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: compare one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (rd_valid !== it.v) begin
                    errors++;
                    $display("FAIL %s: rd_valid=%0b expected %0b", tag_name(it.tag), rd_valid, it.v);
                end else if (it.cmp && rd_data !== it.data) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected %h", tag_name(it.tag), rd_data, it.data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            report();
        end
    end

    initial begin
        // R1: quiet during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_valid=%0b expected 0", rd_valid);
        end
        rst_n = 1'b1;

        // R1 / R6: preload everything, no valid in between
        for (int k = 0; k < TOTAL; k++) do_write(k, pattern(k));
        do_idle(1);

        // R3: aligned reads, with an idle cycle after each (R2)
        for (int r = 0; r < ROWS; r++) begin
            do_read(r * LANES, 3);
            do_idle(2);
        end

        // R4 and R9: every unaligned offset, back to back
        for (int a = 1; a < TOTAL - LANES; a++) begin
            if (a % LANES != 0) do_read(a, 4);
        end

        // R5: reads crossing the top of the address space
        do_read(TOTAL - 3, 5);
        do_read(TOTAL - 2, 5);
        do_read(TOTAL - 1, 5);
        do_idle(8);

        // R6: overwrite, then read across the changed words
        do_write(9, 32'hDEAD_0009);
        do_write(10, 32'hBEEF_0010);
        do_read(8, 6);
        do_read(7, 6);

        // R7: collision drops the read; R8: data holds over it
        do_collide(0, 20, 32'h1234_5678);
        do_idle(8);
        do_read(18, 7);
        do_idle(8);
        do_write(3, 32'hAAAA_5555);
        do_idle(8);
        do_read(2, 6);

        // R9: sequential stream, one read per cycle
        for (int a = 0; a < TOTAL; a++) do_read(a, 9);
        do_idle(2);
        do_idle(8);
        do_idle(8);

        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule